// File: doc/BRIEF.md
# Write-Leveling Calibrator

This block runs the write-leveling calibration of a DDR3 memory interface. On a start request it asks the memory to enter its leveling mode. It then sweeps a shared delay-tap index over the full range of each byte lane's DQS output delay. In that mode the memory samples CK on every rising DQS edge and sends the sampled level back on the lane's DQ. The block reads that level through an ordinary flip-flop input for each lane. The tap range is meant to be centred on nominal DQS/CK alignment, so one upward sweep covers skew in both directions.

At every tap the block waits for the delay line to settle. It then requests three DQS pulses and takes the majority of the three returned samples, which filters out readings made near the sampling boundary. Each lane is judged on its own. A lane locks at the first tap whose majority is 1 when the previous tap's majority was 0. From then on its delay output is held at that tap. A lane that never shows this 0-to-1 change is marked failed. When every lane has locked, or the last tap has been evaluated, the block asks the memory to leave leveling mode and pulses done.

Top module: `wlevel_cal`

## Requirements
- R1: While rst_n is low and in the first cycle after release, lvl_on, lvl_off, dqs_pulse, done and every fail bit are 0, and every tap_out and result field is 0.
- R2: A start seen while idle makes lvl_on high for exactly one cycle, in the next cycle. A start seen during a calibration has no effect on any output.
- R3: After each tap change, tap_out holds for SETTLE cycles with dqs_pulse low before the first DQS pulse of that tap. tap_out does not change while dqs_pulse is high.
- R4: Each tap receives exactly three dqs_pulse strobes, each one cycle long and each followed by one low cycle. fb is used only in the cycle right after a strobe, and its value in any other cycle is ignored.
- R5: For each lane, the value of a tap is the majority (at least two ones) of the three fb samples taken at that tap.
- R6: A lane's result is the first tap t of at least 1 whose value is 1 while tap t-1 had value 0. After it locks, the lane's tap_out field stays at t.
- R7: Lanes are calibrated independently. Lane l uses fb[l], the tap_out bits [l*TW +: TW] and the result bits [l*TW +: TW], where TW = clog2(TAPS).
- R8: A lane with no 0-to-1 change over the sweep, including a lane whose value is already 1 at tap 0, gets fail = 1 and result = 0.
- R9: The sweep ends after the evaluation of the tap on which the last lane locks. If not every lane locks, it ends after tap TAPS-1.
- R10: When the sweep ends, lvl_off is high for one cycle and done is high for one cycle in the cycle after that. result and fail then stay unchanged until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Calibration request, honoured when idle |
| fb | input | LANES | Level returned by the memory for each lane (the CK value sampled at DQS) |
| lvl_on | output | 1 | One-cycle request to enter leveling mode |
| lvl_off | output | 1 | One-cycle request to leave leveling mode |
| dqs_pulse | output | 1 | One-cycle request to emit a DQS pulse |
| done | output | 1 | One-cycle completion strobe |
| tap_out | output | LANES*TW | Delay tap applied to each lane's DQS |
| result | output | LANES*TW | Calibrated tap for each lane |
| fail | output | LANES | Lane found no 0-to-1 change |

## Verification
Locking and the end of the sweep can happen in the same evaluation cycle. One run places a lane's edge on tap TAPS-1, so that lane locks exactly as the sweep runs out while other lanes fail. The bench expects that lane to hold a valid result, the failed lanes to show fail, and lvl_off to follow straight after that evaluation. Another run puts every lane's edge on the same tap and asserts start in the middle of the sweep. In that run all lanes must lock together, the sweep must end early, and the stray start must change nothing.

// File: rtl/wlevel_cal.sv
module wlevel_cal #(
  parameter int LANES  = 2,
  parameter int TAPS   = 32,
  parameter int SETTLE = 4,
  localparam int TW = $clog2(TAPS),
  localparam int CW = $clog2(SETTLE + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [LANES-1:0]    fb,
  output logic                lvl_on,
  output logic                lvl_off,
  output logic                dqs_pulse,
  output logic                done,
  output logic [LANES*TW-1:0] tap_out,
  output logic [LANES*TW-1:0] result,
  output logic [LANES-1:0]    fail
);

  typedef enum logic [2:0] {
    S_IDLE, S_ENTER, S_SETTLE, S_PULSE, S_CAPT, S_EVAL, S_EXIT, S_DONE
  } state_t;

  state_t         st;
  logic [TW-1:0]  tap;
  logic [CW-1:0]  cnt;
  logic [1:0]     pk;
  logic [1:0]     ones  [LANES];
  logic [TW-1:0]  res   [LANES];
  logic [LANES-1:0] zprev, found, fnext;

  assign lvl_on    = (st == S_ENTER);
  assign lvl_off   = (st == S_EXIT);
  assign dqs_pulse = (st == S_PULSE);
  assign done      = (st == S_DONE);

  always_comb
    for (int l = 0; l < LANES; l++)
      fnext[l] = found[l] | (ones[l][1] & zprev[l]);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign tap_out[g*TW +: TW] = found[g] ? res[g] : tap;
    assign result[g*TW +: TW]  = res[g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      tap   <= '0;
      cnt   <= '0;
      pk    <= '0;
      zprev <= '0;
      found <= '0;
      fail  <= '0;
      for (int l = 0; l < LANES; l++) begin
        ones[l] <= '0;
        res[l]  <= '0;
      end
    end else begin
      case (st)
        S_IDLE: if (start) st <= S_ENTER;
        S_ENTER: begin
          tap   <= '0;
          cnt   <= '0;
          pk    <= '0;
          zprev <= '0;
          found <= '0;
          fail  <= '0;
          for (int l = 0; l < LANES; l++) begin
            ones[l] <= '0;
            res[l]  <= '0;
          end
          st <= S_SETTLE;
        end
        S_SETTLE:
          if (cnt == CW'(SETTLE - 1)) st <= S_PULSE;
          else cnt <= cnt + 1'b1;
        S_PULSE: st <= S_CAPT;
        S_CAPT: begin
          for (int l = 0; l < LANES; l++)
            ones[l] <= ones[l] + {1'b0, fb[l]};
          if (pk == 2'd2) st <= S_EVAL;
          else begin
            pk <= pk + 1'b1;
            st <= S_PULSE;
          end
        end
        S_EVAL: begin
          for (int l = 0; l < LANES; l++) begin
            if (fnext[l] && !found[l]) res[l] <= tap;
            zprev[l] <= ~ones[l][1];
            ones[l]  <= '0;
          end
          found <= fnext;
          cnt   <= '0;
          pk    <= '0;
          if ((&fnext) || tap == TW'(TAPS - 1)) begin
            fail <= ~fnext;
            st   <= S_EXIT;
          end else begin
            tap <= tap + 1'b1;
            st  <= S_SETTLE;
          end
        end
        S_EXIT:  st <= S_DONE;
        S_DONE:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

module wlevel_cal_chk #(
  parameter int W = 10
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         lvl_on,
  input logic         lvl_off,
  input logic         dqs_pulse,
  input logic         done,
  input logic [W-1:0] tap_out
);

  // R2
  lvl_on_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_on |-> $past(start));

  // R2
  lvl_on_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_on |=> !lvl_on);

  // R4
  pulse_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dqs_pulse |=> !dqs_pulse);

  // R3
  tap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dqs_pulse |-> $stable(tap_out));

  // R10
  off_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lvl_off |=> done);

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lvl_on, lvl_off, dqs_pulse, done}));

endmodule

bind wlevel_cal wlevel_cal_chk #(.W($bits(tap_out))) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .lvl_on(lvl_on),
  .lvl_off(lvl_off), .dqs_pulse(dqs_pulse), .done(done), .tap_out(tap_out)
);

// File: tb/wlevel_cal_test.sv
module wlevel_cal_test;
  localparam int LANES = 4, TAPS = 32, SETTLE = 4, TW = 5;

  logic clk = 0, rst_n = 0, start = 0;
  logic [LANES-1:0] fb = '0;
  logic lvl_on, lvl_off, dqs_pulse, done;
  logic [LANES*TW-1:0] tap_out, result;
  logic [LANES-1:0] fail;

  int errors = 0, checks = 0, cycles = 0;
  int edge_at [LANES];
  int pk = 0;

  always #2.5 clk = ~clk;

  wlevel_cal #(.LANES(LANES), .TAPS(TAPS), .SETTLE(SETTLE)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .fb(fb), .lvl_on(lvl_on),
    .lvl_off(lvl_off), .dqs_pulse(dqs_pulse), .done(done),
    .tap_out(tap_out), .result(result), .fail(fail));

  function automatic logic resp(int t, int e, int k);
    if (t == e - 1) return k == 0;
    if (t == e)     return k != 1;
    return t >= e;
  endfunction

  // memory model: replies one cycle after a pulse, toggles junk otherwise
  always @(posedge clk) begin
    if (dqs_pulse) begin
      for (int l = 0; l < LANES; l++)
        fb[l] <= resp(int'(tap_out[l*TW +: TW]), edge_at[l], pk);
      pk <= (pk == 2) ? 0 : pk + 1;
    end else fb <= ~fb;
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 100000);
        finish_run();
      end
    end
  end

  function automatic int exp_tap(int l, int t);
    bit ok = edge_at[l] >= 1 && edge_at[l] <= TAPS - 1;
    return (ok && t > edge_at[l]) ? edge_at[l] : t;
  endfunction

  task automatic check_taps(int t);
    for (int l = 0; l < LANES; l++)
      check("R6 R7 tap_out", int'(tap_out[l*TW +: TW]), exp_tap(l, t));
  endtask

  task automatic run(int e0, int e1, int e2, int e3, bit poke);
    int last;
    bit all_ok;
    edge_at[0] = e0; edge_at[1] = e1; edge_at[2] = e2; edge_at[3] = e3;
    all_ok = 1;
    last = 0;
    for (int l = 0; l < LANES; l++) begin
      if (edge_at[l] < 1 || edge_at[l] > TAPS - 1) all_ok = 0;
      else if (edge_at[l] > last) last = edge_at[l];
    end
    if (!all_ok) last = TAPS - 1;

    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    check("R2 lvl_on", lvl_on, 1);
    check("R2 dqs_pulse", dqs_pulse, 0);
    for (int t = 0; t <= last; t++) begin
      for (int s = 0; s < SETTLE; s++) begin
        @(negedge clk);
        start = 0;
        check("R3 settle no pulse", dqs_pulse, 0);
        check("R2 lvl_on once", lvl_on, 0);
        check_taps(t);
        if (poke && t == 2 && s == 0) start = 1; // R2: ignored while busy
      end
      for (int p = 0; p < 3; p++) begin
        @(negedge clk);
        start = 0;
        check("R4 pulse", dqs_pulse, 1);
        check_taps(t);
        @(negedge clk);
        check("R4 gap", dqs_pulse, 0);
      end
      @(negedge clk);
      check("R9 no early end", lvl_off, 0);
      check("R4 eval no pulse", dqs_pulse, 0);
    end
    @(negedge clk);
    check("R9 R10 lvl_off", lvl_off, 1);
    check("R10 done not yet", done, 0);
    @(negedge clk);
    check("R10 done", done, 1);
    check("R10 lvl_off once", lvl_off, 0);
    for (int l = 0; l < LANES; l++) begin
      bit ok = edge_at[l] >= 1 && edge_at[l] <= TAPS - 1;
      check("R5 R6 R7 result", int'(result[l*TW +: TW]), ok ? edge_at[l] : 0);
      check("R8 fail", fail[l], !ok);
    end
    @(negedge clk);
    check("R10 done once", done, 0);
    repeat (3) @(negedge clk);
    for (int l = 0; l < LANES; l++) begin
      bit ok = edge_at[l] >= 1 && edge_at[l] <= TAPS - 1;
      check("R10 result held", int'(result[l*TW +: TW]), ok ? edge_at[l] : 0);
      check("R10 fail held", fail[l], !ok);
    end
  endtask

  initial begin
    for (int l = 0; l < LANES; l++) edge_at[l] = 40;
    repeat (3) @(negedge clk);
    check("R1 lvl_on", lvl_on, 0);
    check("R1 dqs_pulse", dqs_pulse, 0);
    check("R1 done", done, 0);
    check("R1 tap_out", int'(tap_out), 0);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    check("R1 result", int'(result), 0);
    check("R1 fail", int'(fail), 0);
    check("R1 lvl_off", lvl_off, 0);
    run(7, 12, 20, 3, 0);    // distinct edges, early end at 20
    run(0, 31, 40, 16, 0);   // tap-0 high, last-tap lock, no edge
    run(5, 5, 5, 5, 1);      // simultaneous locks, stray start
    run(1, 2, 30, 9, 0);
    finish_run();
  end
endmodule